// File: doc/BRIEF.md
# Dual-Path SPI Bit-Rate Timer

This block derives SPI serial-clock timing from a fast source clock without producing a derived clock. It emits one-source-cycle enable pulses that tell a shift engine when the serial clock should rise and when it should fall. The shift engine and any clock gating sit outside this block.

The half-bit period comes from one of two divider laws, chosen by a path-select input. The power-of-two path divides the source by 4·2^E, where E is a 3-bit exponent. The linear path divides the source by 2·(K+1), where K is an 8-bit divisor. An optional 16-bit guard count adds source cycles between chip-select assertion and the first clock edge, and the same count again between the last clock edge and chip-select release.

A burst starts when `run` and `burst_req` are both high while the block is idle. It ends at the first completed bit (a fall pulse) at which `burst_req` is low. The divider and guard settings are captured only while idle, so a burst always keeps one timing from start to end.

Top module: `spi_sclk_timer`

## Requirements
- R1: While `rst` is high, or in the cycle after `run` is seen low, `cs_active`, `sclk_rise` and `sclk_fall` are all 0. Dropping `run` in the middle of a burst abandons it with no further pulses.
- R2: With `cfg_path_sel`=0, consecutive edge pulses are exactly 2^(E+1) source cycles apart (bit period 4·2^E, i.e. 4, 8, 16, 32 for E=0..3 and 512 for E=7). `cfg_div` has no effect on this path.
- R3: With `cfg_path_sel`=1, consecutive edge pulses are exactly K+1 source cycles apart (bit period 2·(K+1), 2 to 512). `cfg_exp` has no effect on this path.
- R4: Within a burst the pulses alternate and start with a rise. A rise and a fall never occur in the same cycle, and the high and low halves of every bit are equal.
- R5: Divider, path and guard settings are captured only while idle. Changes made during a burst do not alter that burst's timing.
- R6: Let D be `cfg_dly` when `cfg_dly_en`=1, and 0 otherwise. Let H be the half period. The first rise pulse comes D+H-1 cycles after the first cycle in which `cs_active` is high.
- R7: After the final fall pulse (cycle m), `cs_active` stays high through cycle m+D and is low from cycle m+D+1.
- R8: `burst_req` is examined at each fall pulse. If it is low there, no further edge pulses are produced in that burst, so the number of rises equals the number of falls equals the number of bits requested.
- R9: `cs_active` rises in the cycle after `run`=1 and `burst_req`=1 are seen in the idle state. It stays low while `burst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Global enable; low forces idle |
| burst_req | input | 1 | Request to start or continue a burst |
| cfg_path_sel | input | 1 | 0 = power-of-two path, 1 = linear path |
| cfg_exp | input | 3 | Power-of-two exponent E |
| cfg_div | input | 8 | Linear divisor K |
| cfg_dly | input | 16 | Chip-select guard count |
| cfg_dly_en | input | 1 | Enables the guard count |
| sclk_rise | output | 1 | One-cycle serial-clock rise enable |
| sclk_fall | output | 1 | One-cycle serial-clock fall enable |
| cs_active | output | 1 | Chip-select window (high from lead guard to trail guard) |

## Verification
The hardest situation to reach from the ports is a settings change in the middle of a burst that has to leave that burst's timing untouched. The stimulus changes the divisor, path and exponent right after the first rise pulse, then confirms that every later edge gap still matches the captured setting. Two other corners need exact cycle placement: the single-cycle half period on the linear path, where rise and fall pulses fall on adjacent cycles, and the end of a burst. For the end, the request is dropped on the negative edge right after the last wanted rise, so the next fall pulse sees it low.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_CLOCK = 2'd2,
        ST_TRAIL = 2'd3
    } seq_state_e;

    typedef enum logic {
        PATH_POW2   = 1'b0,
        PATH_LINEAR = 1'b1
    } path_e;

    // Half period, in source cycles, of the power-of-two law: 2^(e+1)
    function automatic int unsigned pow2_half(input int unsigned e);
        return 32'd1 << (e + 1);
    endfunction

    // Half period, in source cycles, of the linear law: k+1
    function automatic int unsigned linear_half(input int unsigned k);
        return k + 1;
    endfunction

    // Counter width that holds the largest half period of either law
    function automatic int unsigned half_width(input int unsigned exp_w,
                                               input int unsigned div_w);
        int unsigned top_pow2;
        top_pow2 = (32'd1 << exp_w);
        return ((top_pow2 > div_w) ? top_pow2 : div_w) + 1;
    endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
    import spi_sclk_pkg::*;
#(
    parameter int EXP_W  = 3,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 16,
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              path_sel,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [DLY_W-1:0]  dly_in,
    input  logic              dly_en,
    output logic [HALF_W-1:0] half_q,
    output logic [DLY_W-1:0]  guard_q
);
    logic [HALF_W-1:0] half_d;
    logic [DLY_W-1:0]  guard_d;
    path_e             path;

    assign path = path_e'(path_sel);

    always_comb begin
        if (path == PATH_LINEAR)
            half_d = HALF_W'(linear_half(int'(div_in)));
        else
            half_d = HALF_W'(pow2_half(int'(exp_in)));
        guard_d = dly_en ? dly_in : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= HALF_W'(2);
            guard_q <= '0;
        end else if (capture) begin
            half_q  <= half_d;
            guard_q <= guard_d;
        end
    end

    // R2 R3: a captured half period is never zero
    a_r3_half_nonzero: assert property (@(posedge clk) disable iff (rst)
        half_q != '0);

endmodule

// File: rtl/sclk_edge_ctr.sv
module sclk_edge_ctr #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [HALF_W-1:0] half,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt_q;
    logic              phase_q;
    logic              wrap;
    logic              last_rise_q;

    assign wrap = active && (cnt_q == half - HALF_W'(1));
    assign rise = wrap && !phase_q;
    assign fall = wrap && phase_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + HALF_W'(1);
        end
    end

    // Edge history kept for checking only
    always_ff @(posedge clk) begin
        if (rst || !active)
            last_rise_q <= 1'b0;
        else if (rise)
            last_rise_q <= 1'b1;
        else if (fall)
            last_rise_q <= 1'b0;
    end

    // R4: a rise never follows a rise, a fall never follows a fall
    a_r4_rise_alternates: assert property (@(posedge clk) disable iff (rst)
        rise |-> !last_rise_q);
    a_r4_fall_alternates: assert property (@(posedge clk) disable iff (rst)
        fall |-> last_rise_q);
    // R2 R3: the count stays below the half period
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q < half));

endmodule

// File: rtl/sclk_guard_ctr.sv
module sclk_guard_ctr #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             count_en,
    input  logic [DLY_W-1:0] target,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    assign done = count_en && (cnt_q == target - DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (count_en)
            cnt_q <= cnt_q + DLY_W'(1);
    end

    // R6 R7: the guard window never outruns its target
    a_r6_guard_bound: assert property (@(posedge clk) disable iff (rst)
        (count_en && !clear) |-> (cnt_q < target));

endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer
    import spi_sclk_pkg::*;
#(
    parameter int EXP_W = 3,
    parameter int DIV_W = 8,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             burst_req,
    input  logic             cfg_path_sel,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             cfg_dly_en,
    output logic             sclk_rise,
    output logic             sclk_fall,
    output logic             cs_active
);
    localparam int HALF_W = half_width(EXP_W, DIV_W);

    seq_state_e        seq_q, seq_d;
    logic [HALF_W-1:0] half_q;
    logic [DLY_W-1:0]  guard_q;
    logic [DLY_W-1:0]  guard_in;
    logic              guard_done;
    logic              in_guard;
    logic              clock_on;
    logic              start;

    assign guard_in  = cfg_dly_en ? cfg_dly : '0;
    assign start     = run && burst_req;
    assign in_guard  = (seq_q == ST_LEAD) || (seq_q == ST_TRAIL);
    assign clock_on  = run && (seq_q == ST_CLOCK);
    assign cs_active = (seq_q != ST_IDLE);

    sclk_cfg_hold #(
        .EXP_W (EXP_W),
        .DIV_W (DIV_W),
        .DLY_W (DLY_W),
        .HALF_W(HALF_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .capture (seq_q == ST_IDLE),
        .path_sel(cfg_path_sel),
        .exp_in  (cfg_exp),
        .div_in  (cfg_div),
        .dly_in  (cfg_dly),
        .dly_en  (cfg_dly_en),
        .half_q  (half_q),
        .guard_q (guard_q)
    );

    sclk_edge_ctr #(
        .HALF_W(HALF_W)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .active(clock_on),
        .half  (half_q),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    sclk_guard_ctr #(
        .DLY_W(DLY_W)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .clear   (seq_q != seq_d),
        .count_en(in_guard),
        .target  (guard_q),
        .done    (guard_done)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            ST_IDLE:  if (start) seq_d = (guard_in != '0) ? ST_LEAD : ST_CLOCK;
            ST_LEAD:  if (guard_done) seq_d = ST_CLOCK;
            ST_CLOCK: if (sclk_fall && !burst_req)
                          seq_d = (guard_q != '0) ? ST_TRAIL : ST_IDLE;
            ST_TRAIL: if (guard_done) seq_d = ST_IDLE;
            default:  seq_d = ST_IDLE;
        endcase
        if (!run) seq_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= ST_IDLE;
        else     seq_q <= seq_d;
    end

    // R1: run low silences the block from the next cycle
    a_r1_run_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!cs_active && !sclk_rise && !sclk_fall));
    // R9: a request seen while idle opens the chip-select window
    a_r9_cs_opens: assert property (@(posedge clk) disable iff (rst)
        (!cs_active && run && burst_req) |=> cs_active);
    // R5: the captured half period holds for the whole burst
    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (cs_active && run) |=> $stable(half_q));
    // R7 R8: no edge pulses during the guard windows
    a_r8_quiet_guards: assert property (@(posedge clk) disable iff (rst)
        in_guard |-> (!sclk_rise && !sclk_fall));
    // R4: pulses only inside the chip-select window
    a_r4_pulse_in_window: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise || sclk_fall) |-> cs_active);

endmodule

// File: tb/sim_spi_sclk_timer.sv
module sim_spi_sclk_timer;

    typedef struct packed {
        logic        sel;
        logic [2:0]  ex;
        logic [7:0]  dv;
        logic        den;
        logic [15:0] dly;
        logic [3:0]  nbits;
        logic [9:0]  half;   // expected half period
        logic [15:0] dexp;   // expected effective guard
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 3'd0, 8'd0,   1'b0, 16'd0,  4'd3, 10'd2,   16'd0},  // R2 E=0 div 4
        '{1'b0, 3'd1, 8'd0,   1'b1, 16'd3,  4'd2, 10'd4,   16'd3},  // R2 E=1 div 8, R6 guard
        '{1'b0, 3'd3, 8'd0,   1'b0, 16'd0,  4'd1, 10'd16,  16'd0},  // R2 E=3 div 32
        '{1'b0, 3'd7, 8'd0,   1'b0, 16'd0,  4'd1, 10'd256, 16'd0},  // R2 E=7 div 512
        '{1'b1, 3'd0, 8'd0,   1'b1, 16'd2,  4'd4, 10'd1,   16'd2},  // R3 K=0 div 2
        '{1'b1, 3'd0, 8'd4,   1'b0, 16'd0,  4'd2, 10'd5,   16'd0},  // R3 K=4
        '{1'b1, 3'd0, 8'd255, 1'b1, 16'd1,  4'd1, 10'd256, 16'd1},  // R3 K=255
        '{1'b0, 3'd2, 8'd0,   1'b0, 16'd50, 4'd2, 10'd8,   16'd0},  // R6 guard disabled
        '{1'b1, 3'd6, 8'd7,   1'b0, 16'd0,  4'd2, 10'd8,   16'd0}   // R3 exponent ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        burst_req = 1'b0;
    logic        cfg_path_sel = 1'b0;
    logic [2:0]  cfg_exp = '0;
    logic [7:0]  cfg_div = '0;
    logic [15:0] cfg_dly = '0;
    logic        cfg_dly_en = 1'b0;
    logic        sclk_rise, sclk_fall, cs_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    spi_sclk_timer u0 (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .burst_req   (burst_req),
        .cfg_path_sel(cfg_path_sel),
        .cfg_exp     (cfg_exp),
        .cfg_div     (cfg_div),
        .cfg_dly     (cfg_dly),
        .cfg_dly_en  (cfg_dly_en),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .cs_active   (cs_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one burst and measures it at negative edges; t counts cycles since request
    task automatic run_burst(input vec_t v, input bit mutate, input string tag);
        int t = 0, cs_first = -1, first_rise = -1, last_fall = -1, cs_low = -1;
        int prev_edge = -1, gap_err = 0, alt_err = 0, nr = 0, nf = 0;
        bit want_rise = 1'b1;
        cfg_path_sel = v.sel; cfg_exp = v.ex; cfg_div = v.dv;
        cfg_dly = v.dly; cfg_dly_en = v.den;
        burst_req = 1'b1;
        while (t < 4000 && cs_low < 0) begin
            @(negedge clk);
            t++;
            if (cs_active && cs_first < 0) cs_first = t;
            if (!cs_active && cs_first >= 0) cs_low = t;
            if (sclk_rise && sclk_fall) alt_err++;
            if (sclk_rise || sclk_fall) begin
                if (sclk_rise != want_rise) alt_err++;
                want_rise = !sclk_rise;
                if (prev_edge >= 0 && (t - prev_edge) != int'(v.half)) gap_err++;
                prev_edge = t;
            end
            if (sclk_rise) begin
                nr++;
                if (first_rise < 0) first_rise = t;
                if (mutate && nr == 1) begin
                    cfg_div = 8'd9; cfg_path_sel = 1'b0; cfg_exp = 3'd5; cfg_dly = 16'd40;
                end
                if (nr == int'(v.nbits)) burst_req = 1'b0;
            end
            if (sclk_fall) begin
                nf++;
                last_fall = t;
            end
        end
        check(cs_first == 1, {tag, " R9 cs opens"}, cs_first, 1);
        check(first_rise == 1 + int'(v.dexp) + int'(v.half) - 1, {tag, " R6 first rise"},
              first_rise, int'(v.dexp) + int'(v.half));
        check(gap_err == 0, v.sel ? {tag, " R3 gaps"} : {tag, " R2 gaps"}, gap_err, 0);
        check(alt_err == 0, {tag, " R4 alternation"}, alt_err, 0);
        check(nr == int'(v.nbits) && nf == int'(v.nbits), {tag, " R8 edge count"},
              nr * 100 + nf, int'(v.nbits) * 101);
        check(cs_low == last_fall + int'(v.dexp) + 1, {tag, " R7 cs release"},
              cs_low, last_fall + int'(v.dexp) + 1);
        burst_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R1: reset holds everything quiet even with a request pending
        run = 1'b1; burst_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!cs_active && !sclk_rise && !sclk_fall, "R1 reset state",
                  {cs_active, sclk_rise, sclk_fall}, 0);
        end
        burst_req = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!cs_active, "R9 idle without request", cs_active, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_burst(TBL[i], 1'b0, $sformatf("vec%0d", i));
        end

        // R5: settings changed mid-burst leave the burst at half period 3
        run_burst('{1'b1, 3'd0, 8'd2, 1'b0, 16'd0, 4'd3, 10'd3, 16'd0}, 1'b1, "mutate R5");
        // The next burst picks up the new settings: E=5 gives half 64, guard off
        run_burst('{1'b0, 3'd5, 8'd9, 1'b0, 16'd0, 4'd1, 10'd64, 16'd0}, 1'b0, "recapture R5");

        // R1: dropping run in mid-burst abandons it
        cfg_path_sel = 1'b0; cfg_exp = 3'd2; cfg_dly_en = 1'b0;
        burst_req = 1'b1;
        for (int i = 0; i < 40 && !sclk_rise; i++) @(negedge clk);
        check(sclk_rise, "R1 burst running", sclk_rise, 1);
        run = 1'b0;
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (cs_active || sclk_rise || sclk_fall) bad++;
            end
            check(bad == 0, "R1 run low abandons burst", bad, 0);
        end
        burst_req = 1'b0;
        run = 1'b1;
        begin
            int bad = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (cs_active) bad++;
            end
            check(bad == 0, "R9 no request stays idle", bad, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule